// File: doc/BRIEF.md
# Ingress Frame Priority Classifier

This block watches the opening bytes of each frame as it enters a switch port and decides which of four egress priority queues the frame belongs in. Bytes arrive one per cycle with a start marker on the first byte, an end marker on the last, and the number of the port they came in on. The block detects an 802.1Q tag, reads the EtherType, and pulls the differentiated-services code point out of an IPv4 or IPv6 header. It then picks one 3-bit priority from a ranked list of sources and turns that priority into a 2-bit queue number through a small lookup table.

The priority sources are ranked as follows. A destination-address priority, supplied by the forwarding lookup, wins when it is valid and enabled. Next comes an IP-derived value. This is either a DSCP-indexed table entry or the raw IPv4 precedence bits. Next comes the frame's tag PCP, remapped through a per-port regeneration table. Last comes a per-port default. Every table and enable is a plain register input, so the block holds no configuration state of its own. The result is presented as a one-cycle pulse. The pulse comes as soon as the bytes that decide the outcome have arrived, or at the end of a frame that is too short to reach them.

Top module: `prio_classifier`

## Requirements
- R1: While reset is held and on the first cycle after it, `res_valid` is 0 and `res_prio`, `res_queue` and `res_src` are 0.
- R2: Each frame yields exactly one `res_valid` pulse, one cycle after the byte at offset 15 (untagged) or offset 19 (tagged), counting the start-marked byte as offset 0. Bytes after that point, and bytes without a start marker after a result, produce no further pulse.
- R3: A frame whose end-marked byte comes before the deciding offset yields its pulse one cycle after that end byte, using only the fields already seen. The PCP counts only if offset 14 arrived, and the IP fields count only if the deciding offset arrived.
- R4: A frame is tagged when bytes 12–13 equal 0x8100. Its PCP is bits 7:5 of byte 14. Tags with a zero VID and with a nonzero VID are treated alike. With the VLAN source enabled and no higher source active, the priority is entry PCP of the ingress port's regeneration table, and `res_src` = 1.
- R5: With EtherType 0x0800 (bytes 12–13 untagged, 16–17 tagged) and DSCP mapping enabled, DSCP = bits 7:2 of the IP header's second byte (offset 15 or 19). The priority is DSCP table entry DSCP, and `res_src` = 2.
- R6: With EtherType 0x86DD, DSCP = {low nibble of the first IP byte, bits 7:6 of the second}, looked up in the same DSCP table. With DSCP mapping disabled, IPv6 supplies no priority.
- R7: With DSCP mapping disabled, an IPv4 frame takes bits 7:5 of its TOS byte as its priority, and `res_src` = 2.
- R8: A frame whose type/length field is neither 0x0800 nor 0x86DD (including 802.3 length values) gets no IP priority.
- R9: When `da_valid` and `cfg_da_en` are both high in the cycle of the deciding byte, the priority is `da_prio` and `res_src` = 3, ahead of all other sources. With `cfg_da_en` low, `da_valid` has no effect.
- R10: When no other source applies, the priority is the ingress port's default entry, and `res_src` = 0.
- R11: `res_queue` equals traffic-class table entry `res_prio` (2 bits per entry, entry i at bits 2i+1:2i).
- R12: `cfg_ip_en` low removes the IP source, and `cfg_vlan_en` low removes the VLAN source. Lower-ranked sources then apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A frame byte is present |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| in_port | input | PORT_W | Ingress port, sampled with the first byte |
| da_valid | input | 1 | Destination-address priority is available |
| da_prio | input | 3 | Destination-address priority |
| cfg_da_en | input | 1 | Allow the destination-address source |
| cfg_ip_en | input | 1 | Allow the IP source |
| cfg_dscp_en | input | 1 | Map DSCP through the table (else IPv4 precedence) |
| cfg_vlan_en | input | 1 | Allow the tag PCP source |
| dscp_tbl | input | 192 | 64 entries of 3 bits, entry i at bits 3i+2:3i |
| regen_tbl | input | NUM_PORTS*24 | Per-port 8-entry PCP map, entry (p,k) at 3(8p+k) |
| dflt_tbl | input | NUM_PORTS*3 | Per-port default priority |
| tc_tbl | input | 16 | Priority to queue map, 2 bits per entry |
| res_valid | output | 1 | One-cycle result strobe |
| res_prio | output | 3 | Resolved priority |
| res_queue | output | 2 | Egress queue number |
| res_src | output | 2 | Winning source: 0 default, 1 VLAN, 2 IP, 3 DA |

## Verification
Every result is due exactly one cycle after the deciding byte is presented. The deciding byte is at offset 15 or 19, or is the end byte of a short frame. The decision itself is combinational on that byte, and one output register follows it. The bench drives each byte on a falling edge and checks `res_valid` on the following falling edge. It therefore knows which byte raised any pulse, compares that byte with the offset the requirements predict, and keeps watching idle cycles afterwards so that a late or repeated pulse is caught.

// File: rtl/pc_pkg.sv
`timescale 1ns/1ps
package pc_pkg;
  localparam int PRIO_W  = 3;
  localparam int QUEUE_W = 2;
  localparam int DSCP_W  = 6;
  localparam int PRIO_N  = 1 << PRIO_W;
  localparam int DSCP_N  = 1 << DSCP_W;

  localparam logic [15:0] TPID_VLAN = 16'h8100;
  localparam logic [15:0] ET_IPV4   = 16'h0800;
  localparam logic [15:0] ET_IPV6   = 16'h86DD;

  typedef enum logic [1:0] {
    SRC_DFLT = 2'd0,
    SRC_VLAN = 2'd1,
    SRC_IP   = 2'd2,
    SRC_DA   = 2'd3
  } src_e;

  typedef struct packed {
    logic              pcp_ok;
    logic [PRIO_W-1:0] pcp;
    logic              is_v4;
    logic              is_v6;
    logic [DSCP_W-1:0] dscp;
  } hdr_t;
endpackage

// File: rtl/pc_hdr_parser.sv
`timescale 1ns/1ps
module pc_hdr_parser import pc_pkg::*; #(
  parameter int PORT_W = 2,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  input  logic [PORT_W-1:0] in_port,
  output logic              fire,
  output hdr_t              hdr,
  output logic [PORT_W-1:0] port
);
  // byte offsets of the fields (R2, R4, R5, R6)
  localparam logic [OFF_W-1:0] O_TYPE_LO = OFF_W'(13);
  localparam logic [OFF_W-1:0] O_TCI_HI  = OFF_W'(14);
  localparam logic [OFF_W-1:0] O_ETYP_T  = OFF_W'(17);
  localparam logic [OFF_W-1:0] O_IP0_U   = OFF_W'(14);
  localparam logic [OFF_W-1:0] O_IP0_T   = OFF_W'(18);
  localparam logic [OFF_W-1:0] O_TOS_U   = OFF_W'(15);
  localparam logic [OFF_W-1:0] O_TOS_T   = OFF_W'(19);
  localparam logic [OFF_W-1:0] O_MAX     = '1;

  logic [OFF_W-1:0]  off_q, off;
  logic              done_q, take, tos_hit;
  logic              tag_q, tag_b, tag_n;
  logic [7:0]        prev_q;
  logic [15:0]       et_q, et_b, et_n;
  logic [3:0]        ip0_q, ip0_b, ip0_n;
  logic [PRIO_W-1:0] pcp_q, pcp_b, pcp_n;
  logic              pok_q, pok_b, pok_n;
  logic [PORT_W-1:0] port_q;

  always_comb begin
    off   = in_sof ? '0 : off_q;
    tag_b = in_sof ? 1'b0 : tag_q;
    et_b  = in_sof ? '0 : et_q;
    ip0_b = in_sof ? '0 : ip0_q;
    pcp_b = in_sof ? '0 : pcp_q;
    pok_b = in_sof ? 1'b0 : pok_q;
    tag_n = tag_b;
    et_n  = et_b;
    ip0_n = ip0_b;
    pcp_n = pcp_b;
    pok_n = pok_b;
    if (off == O_TYPE_LO) begin
      tag_n = ({prev_q, in_data} == TPID_VLAN);
      et_n  = {prev_q, in_data};
    end
    if (tag_b && off == O_TCI_HI) begin
      pcp_n = in_data[7:5];
      pok_n = 1'b1;
    end
    if (tag_b && off == O_ETYP_T) et_n = {prev_q, in_data};
    if (off == (tag_b ? O_IP0_T : O_IP0_U)) ip0_n = in_data[3:0];
    tos_hit = (off == (tag_b ? O_TOS_T : O_TOS_U));
    take    = in_valid && (in_sof || !done_q);
    fire    = take && (in_eof || tos_hit);
    port    = in_sof ? in_port : port_q;
    hdr.pcp_ok = pok_n;
    hdr.pcp    = pcp_n;
    hdr.is_v4  = tos_hit && (et_b == ET_IPV4);
    hdr.is_v6  = tos_hit && (et_b == ET_IPV6);
    hdr.dscp   = hdr.is_v6 ? {ip0_b, in_data[7:6]} : in_data[7:2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      done_q <= 1'b1;
      tag_q  <= 1'b0;
      prev_q <= '0;
      et_q   <= '0;
      ip0_q  <= '0;
      pcp_q  <= '0;
      pok_q  <= 1'b0;
      port_q <= '0;
    end else if (take) begin
      off_q  <= (off == O_MAX) ? off : off + 1'b1;
      done_q <= fire;
      tag_q  <= tag_n;
      prev_q <= in_data;
      et_q   <= et_n;
      ip0_q  <= ip0_n;
      pcp_q  <= pcp_n;
      pok_q  <= pok_n;
      port_q <= port;
    end
  end
endmodule

// File: rtl/pc_prio_resolve.sv
`timescale 1ns/1ps
module pc_prio_resolve import pc_pkg::*; #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 2
) (
  input  hdr_t                        hdr,
  input  logic [PORT_W-1:0]           port,
  input  logic                        da_valid,
  input  logic [PRIO_W-1:0]           da_prio,
  input  logic                        cfg_da_en,
  input  logic                        cfg_ip_en,
  input  logic                        cfg_dscp_en,
  input  logic                        cfg_vlan_en,
  input  logic [DSCP_N*PRIO_W-1:0]    dscp_tbl,
  input  logic [NUM_PORTS*PRIO_N*PRIO_W-1:0] regen_tbl,
  input  logic [NUM_PORTS*PRIO_W-1:0] dflt_tbl,
  output logic [PRIO_W-1:0]           prio,
  output src_e                        src
);
  logic              ip_ok, port_ok;
  logic [PRIO_W-1:0] ip_prio, vlan_prio, dflt_prio;
  int                pi;

  always_comb begin
    pi      = int'(port);
    port_ok = (pi < NUM_PORTS);
    // R6: IPv6 only counts when DSCP mapping is on; R8: other types never
    ip_ok   = cfg_ip_en && (hdr.is_v4 || (hdr.is_v6 && cfg_dscp_en));
    // R5/R7
    ip_prio = cfg_dscp_en ? dscp_tbl[int'(hdr.dscp)*PRIO_W +: PRIO_W]
                          : hdr.dscp[DSCP_W-1 -: PRIO_W];
    vlan_prio = port_ok ? regen_tbl[(pi*PRIO_N + int'(hdr.pcp))*PRIO_W +: PRIO_W] : '0;
    dflt_prio = port_ok ? dflt_tbl[pi*PRIO_W +: PRIO_W] : '0;
    // fixed ranking: R9, then IP, then R4, then R10
    if (da_valid && cfg_da_en) begin
      prio = da_prio;
      src  = SRC_DA;
    end else if (ip_ok) begin
      prio = ip_prio;
      src  = SRC_IP;
    end else if (cfg_vlan_en && hdr.pcp_ok) begin
      prio = vlan_prio;
      src  = SRC_VLAN;
    end else begin
      prio = dflt_prio;
      src  = SRC_DFLT;
    end
  end
endmodule

// File: rtl/pc_result_reg.sv
`timescale 1ns/1ps
module pc_result_reg import pc_pkg::*; (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fire,
  input  logic [PRIO_W-1:0]         prio,
  input  src_e                      src,
  input  logic [PRIO_N*QUEUE_W-1:0] tc_tbl,
  output logic                      res_valid,
  output logic [PRIO_W-1:0]         res_prio,
  output logic [QUEUE_W-1:0]        res_queue,
  output logic [1:0]                res_src
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_prio  <= '0;
      res_queue <= '0;
      res_src   <= '0;
    end else begin
      res_valid <= fire;
      if (fire) begin
        res_prio  <= prio;
        res_queue <= tc_tbl[int'(prio)*QUEUE_W +: QUEUE_W]; // R11
        res_src   <= src;
      end
    end
  end
endmodule

// File: rtl/prio_classifier.sv
`timescale 1ns/1ps
module prio_classifier import pc_pkg::*; #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               in_valid,
  input  logic                               in_sof,
  input  logic                               in_eof,
  input  logic [7:0]                         in_data,
  input  logic [PORT_W-1:0]                  in_port,
  input  logic                               da_valid,
  input  logic [PRIO_W-1:0]                  da_prio,
  input  logic                               cfg_da_en,
  input  logic                               cfg_ip_en,
  input  logic                               cfg_dscp_en,
  input  logic                               cfg_vlan_en,
  input  logic [DSCP_N*PRIO_W-1:0]           dscp_tbl,
  input  logic [NUM_PORTS*PRIO_N*PRIO_W-1:0] regen_tbl,
  input  logic [NUM_PORTS*PRIO_W-1:0]        dflt_tbl,
  input  logic [PRIO_N*QUEUE_W-1:0]          tc_tbl,
  output logic                               res_valid,
  output logic [PRIO_W-1:0]                  res_prio,
  output logic [QUEUE_W-1:0]                 res_queue,
  output logic [1:0]                         res_src
);
  logic              fire;
  hdr_t              hdr;
  logic [PORT_W-1:0] port;
  logic [PRIO_W-1:0] prio;
  src_e              src;

  pc_hdr_parser #(.PORT_W(PORT_W), .OFF_W(5)) u_parse (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .in_port(in_port),
    .fire(fire), .hdr(hdr), .port(port)
  );

  pc_prio_resolve #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_resolve (
    .hdr(hdr), .port(port), .da_valid(da_valid), .da_prio(da_prio),
    .cfg_da_en(cfg_da_en), .cfg_ip_en(cfg_ip_en), .cfg_dscp_en(cfg_dscp_en),
    .cfg_vlan_en(cfg_vlan_en), .dscp_tbl(dscp_tbl), .regen_tbl(regen_tbl),
    .dflt_tbl(dflt_tbl), .prio(prio), .src(src)
  );

  pc_result_reg u_out (
    .clk(clk), .rst(rst), .fire(fire), .prio(prio), .src(src),
    .tc_tbl(tc_tbl), .res_valid(res_valid), .res_prio(res_prio),
    .res_queue(res_queue), .res_src(res_src)
  );
endmodule

// File: rtl/prio_classifier_chk.sv
`timescale 1ns/1ps
module prio_classifier_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_sof,
  input logic       in_eof,
  input logic       da_valid,
  input logic [2:0] da_prio,
  input logic       cfg_da_en,
  input logic       cfg_ip_en,
  input logic       cfg_vlan_en,
  input logic       res_valid,
  input logic [2:0] res_prio,
  input logic [1:0] res_src
);
  // R2: a pulse lasts one cycle unless a one-byte frame decided right behind it
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> (!res_valid || $past(in_valid && in_sof && in_eof)));

  // R9: an enabled, valid DA priority always wins
  p_da_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(da_valid && cfg_da_en)) |-> (res_src == 2'd3 && res_prio == $past(da_prio)));

  // R9: the DA source never wins while disabled or not valid
  p_da_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_src == 2'd3) |-> $past(da_valid && cfg_da_en));

  // R12: IP source only while enabled
  p_ip_gate_r12: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_src == 2'd2) |-> $past(cfg_ip_en));

  // R12: VLAN source only while enabled
  p_vlan_gate_r12: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_src == 2'd1) |-> $past(cfg_vlan_en));
endmodule

bind prio_classifier prio_classifier_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
  .da_valid(da_valid), .da_prio(da_prio), .cfg_da_en(cfg_da_en),
  .cfg_ip_en(cfg_ip_en), .cfg_vlan_en(cfg_vlan_en), .res_valid(res_valid),
  .res_prio(res_prio), .res_src(res_src)
);

// File: tb/prio_classifier_bench.sv
`timescale 1ns/1ps
module prio_classifier_bench;
  localparam int NP = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = '0;
  logic [1:0] in_port = '0;
  logic da_valid = 0;
  logic [2:0] da_prio = '0;
  logic cfg_da_en = 0, cfg_ip_en = 0, cfg_dscp_en = 0, cfg_vlan_en = 0;
  logic [191:0] dscp_tbl;
  logic [NP*24-1:0] regen_tbl;
  logic [NP*3-1:0] dflt_tbl;
  logic [15:0] tc_tbl;
  logic res_valid;
  logic [2:0] res_prio;
  logic [1:0] res_queue, res_src;

  prio_classifier #(.NUM_PORTS(NP)) u_prio_classifier (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .in_port(in_port), .da_valid(da_valid), .da_prio(da_prio),
    .cfg_da_en(cfg_da_en), .cfg_ip_en(cfg_ip_en), .cfg_dscp_en(cfg_dscp_en),
    .cfg_vlan_en(cfg_vlan_en), .dscp_tbl(dscp_tbl), .regen_tbl(regen_tbl),
    .dflt_tbl(dflt_tbl), .tc_tbl(tc_tbl), .res_valid(res_valid),
    .res_prio(res_prio), .res_queue(res_queue), .res_src(res_src)
  );

  // table contents, independent formulas
  function automatic int f_dscp(input int i); return (i * 5 + 3) % 8; endfunction
  function automatic int f_regen(input int p, input int k); return (k + 2 * p + 1) % 8; endfunction
  function automatic int f_dflt(input int p); return 4 + p; endfunction
  function automatic int f_tc(input int i); return (i * 3 + 1) % 4; endfunction

  // cfg = {da_en, ip_en, dscp_en, vlan_en}
  typedef struct packed {
    logic [6:0]  len;
    logic        tg;
    logic [11:0] vid;
    logic [2:0]  pcp;
    logic [15:0] et;
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic [1:0]  port;
    logic        dav;
    logic [2:0]  dap;
    logic [3:0]  cfg;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{7'd60, 1'b0, 12'd0,   3'd0, 16'h0800, 8'h45, 8'hB8, 2'd0, 1'b0, 3'd0, 4'b1111, 4'd5},  // R5 IPv4 DSCP
    '{7'd60, 1'b0, 12'd0,   3'd0, 16'h0800, 8'h45, 8'hA0, 2'd0, 1'b0, 3'd0, 4'b1101, 4'd7},  // R7 precedence
    '{7'd64, 1'b1, 12'd100, 3'd5, 16'h0800, 8'h45, 8'h68, 2'd1, 1'b0, 3'd0, 4'b1111, 4'd5},  // R5 tagged IPv4
    '{7'd60, 1'b1, 12'd0,   3'd3, 16'h0806, 8'h00, 8'h01, 2'd2, 1'b0, 3'd0, 4'b1111, 4'd4},  // R4 VID zero
    '{7'd60, 1'b1, 12'd5,   3'd6, 16'h0806, 8'h00, 8'h01, 2'd0, 1'b0, 3'd0, 4'b1111, 4'd4},  // R4 VID nonzero
    '{7'd60, 1'b0, 12'd0,   3'd0, 16'h86DD, 8'h6A, 8'hC0, 2'd1, 1'b0, 3'd0, 4'b1111, 4'd6},  // R6 IPv6
    '{7'd64, 1'b1, 12'd7,   3'd2, 16'h86DD, 8'h6A, 8'hC0, 2'd2, 1'b0, 3'd0, 4'b1101, 4'd6},  // R6 IPv6 map off
    '{7'd60, 1'b0, 12'd0,   3'd0, 16'h002E, 8'h45, 8'hB8, 2'd1, 1'b0, 3'd0, 4'b1111, 4'd8},  // R8 length, R10 default
    '{7'd60, 1'b1, 12'd9,   3'd7, 16'h002E, 8'h45, 8'hB8, 2'd2, 1'b0, 3'd0, 4'b1111, 4'd8},  // R8 tagged length
    '{7'd60, 1'b0, 12'd0,   3'd0, 16'h0800, 8'h45, 8'hB8, 2'd0, 1'b1, 3'd2, 4'b1111, 4'd9},  // R9 DA wins
    '{7'd60, 1'b0, 12'd0,   3'd0, 16'h0800, 8'h45, 8'hB8, 2'd0, 1'b1, 3'd2, 4'b0111, 4'd9},  // R9 DA disabled
    '{7'd60, 1'b1, 12'd3,   3'd4, 16'h0800, 8'h45, 8'hB8, 2'd1, 1'b0, 3'd0, 4'b1011, 4'd12}, // R12 IP off
    '{7'd60, 1'b1, 12'd3,   3'd4, 16'h0806, 8'h00, 8'h00, 2'd2, 1'b0, 3'd0, 4'b1110, 4'd12}, // R12 VLAN off
    '{7'd10, 1'b0, 12'd0,   3'd0, 16'h0800, 8'h45, 8'hB8, 2'd1, 1'b0, 3'd0, 4'b1111, 4'd3},  // R3 short
    '{7'd17, 1'b1, 12'd3,   3'd1, 16'h0800, 8'h45, 8'hB8, 2'd0, 1'b0, 3'd0, 4'b1111, 4'd3},  // R3 no IP seen
    '{7'd14, 1'b1, 12'd3,   3'd1, 16'h0800, 8'h45, 8'hB8, 2'd2, 1'b0, 3'd0, 4'b1111, 4'd3}   // R3 no PCP seen
  };

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // model of the ranking, from the requirements
  task automatic model(input vec_t v, output int prio, output int src);
    int  dec;
    bit  tos_seen, pcp_seen, v4, v6;
    int  dscp;
    dec      = v.tg ? 19 : 15;
    tos_seen = (int'(v.len) >= dec + 1);
    pcp_seen = v.tg && (int'(v.len) >= 15);
    v4 = tos_seen && v.et == 16'h0800;
    v6 = tos_seen && v.et == 16'h86DD;
    dscp = v6 ? int'({v.b0[3:0], v.b1[7:6]}) : int'(v.b1[7:2]);
    if (v.cfg[3] && v.dav) begin
      prio = int'(v.dap); src = 3;
    end else if (v.cfg[2] && (v4 || (v6 && v.cfg[1]))) begin
      prio = v.cfg[1] ? f_dscp(dscp) : int'(v.b1[7:5]); src = 2;
    end else if (v.cfg[0] && pcp_seen) begin
      prio = f_regen(int'(v.port), int'(v.pcp)); src = 1;
    end else begin
      prio = f_dflt(int'(v.port)); src = 0;
    end
  endtask

  task automatic run_frame(input vec_t v);
    logic [7:0] b [64];
    int fire_at, pulses, seen_at, p_got, s_got, q_got, ep, es, L;
    string rq;
    L = int'(v.len);
    for (int k = 0; k < 64; k++) b[k] = (k < 12) ? 8'(k * 17 + 1) : 8'h55;
    if (v.tg) begin
      b[12] = 8'h81; b[13] = 8'h00;
      b[14] = {v.pcp, 1'b0, v.vid[11:8]}; b[15] = v.vid[7:0];
      b[16] = v.et[15:8]; b[17] = v.et[7:0]; b[18] = v.b0; b[19] = v.b1;
    end else begin
      b[12] = v.et[15:8]; b[13] = v.et[7:0]; b[14] = v.b0; b[15] = v.b1;
    end
    fire_at = (L - 1 < (v.tg ? 19 : 15)) ? L - 1 : (v.tg ? 19 : 15);
    pulses = 0; seen_at = -1; p_got = 0; s_got = 0; q_got = 0;
    for (int k = 0; k <= L + 2; k++) begin
      @(negedge clk);
      if (k > 0 && res_valid) begin
        pulses++; seen_at = k - 1;
        p_got = int'(res_prio); s_got = int'(res_src); q_got = int'(res_queue);
      end
      if (k < L) begin
        in_valid = 1'b1; in_sof = (k == 0); in_eof = (k == L - 1); in_data = b[k];
        in_port = v.port; da_valid = v.dav; da_prio = v.dap;
        {cfg_da_en, cfg_ip_en, cfg_dscp_en, cfg_vlan_en} = v.cfg;
      end else begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
    end
    model(v, ep, es);
    rq = $sformatf("R%0d", v.req);
    check(pulses == 1, "R2", "pulse count", pulses, 1);
    check(seen_at == fire_at, (L - 1 < fire_at + 1 && L - 1 == fire_at && fire_at < 15) ? "R3" : "R2",
          "pulse byte offset", seen_at, fire_at);
    check(p_got == ep, rq, "priority", p_got, ep);
    check(s_got == es, rq, "source", s_got, es);
    check(q_got == f_tc(ep), "R11", "queue", q_got, f_tc(ep));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) dscp_tbl[i*3 +: 3] = 3'(f_dscp(i));
    for (int p = 0; p < NP; p++) begin
      dflt_tbl[p*3 +: 3] = 3'(f_dflt(p));
      for (int k = 0; k < 8; k++) regen_tbl[(p*8 + k)*3 +: 3] = 3'(f_regen(p, k));
    end
    for (int i = 0; i < 8; i++) tc_tbl[i*2 +: 2] = 2'(f_tc(i));

    // R1: outputs quiet under reset and just after it
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R1", "res_valid in reset", int'(res_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check({res_valid, res_prio, res_queue, res_src} == '0, "R1", "outputs after reset",
          int'({res_valid, res_prio, res_queue, res_src}), 0);

    for (int i = 0; i < NV; i++) run_frame(VECS[i]);

    // R2: bytes without a start marker after a result produce no pulse
    begin
      int extra = 0;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (res_valid) extra++;
        in_valid = 1'b1; in_sof = 1'b0; in_eof = (k == 23); in_data = 8'h81;
      end
      @(negedge clk);
      if (res_valid) extra++;
      in_valid = 1'b0; in_eof = 1'b0;
      @(negedge clk);
      if (res_valid) extra++;
      check(extra == 0, "R2", "stray bytes pulse count", extra, 0);
    end

    // R3 and R10: one-byte frame on port 2 decides at its only byte, default entry
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'h00; in_port = 2'd2;
    da_valid = 1'b0; {cfg_da_en, cfg_ip_en, cfg_dscp_en, cfg_vlan_en} = 4'b1111;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    check(res_valid == 1'b1, "R3", "one-byte frame pulse", int'(res_valid), 1);
    check(int'(res_prio) == f_dflt(2), "R10", "one-byte frame priority", int'(res_prio), f_dflt(2));
    @(negedge clk);
    check(res_valid == 1'b0, "R2", "one-byte frame pulse width", int'(res_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule